// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Generator

This block drives two output pins, each from its own pulse-width channel. Both channels advance on a single shared step enable (`tick_i`). Software sets the block up through a small 32-bit register port. Each channel has a period length N (range) and a high count D (data).

A channel can run in one of two styles:

- **Block style:** the D high steps come first as one run, followed by N-D low steps.
- **Spread style:** the same D high steps are scattered as evenly as possible through the period, using a running-sum density method.

Each channel also has an output invert bit and an idle level. The idle level drives the pin whenever the channel is not producing pulses.

Range and data writes are held back until the current period has finished, so a period is never cut short. Clearing the run bit hands the pin to the idle level straight away. A channel's pulse frequency is the step-enable rate divided by its range. Serializer, FIFO and DMA behaviour are not part of the block. Their control bits and offsets exist only so that the register layout stays compatible.

Top module: `duo_pulse_gen`

## Requirements
- R1: After reset every register reads 0, both channels are idle and both pins are low.
- R2: The control word sits at offset 0x00. Bits 7:0 belong to channel A and bits 15:8 to channel B. Within each byte: +0 run, +1 serializer select, +2 repeat, +3 idle level, +4 invert, +5 fifo select, +6 fifo clear, +7 block style. Bits 6, 14 and 31:16 always read 0; the other bits read back as written. Range and data are at offsets 0x10/0x14 (channel A) and 0x20/0x24 (channel B), and read back as written.
- R3: Offsets 0x04, 0x08, 0x18 and every unassigned offset read 0. Writes to them change no register.
- R4: In block style, period position k (0-based) is high when k < D.
- R5: In spread style, position k is high when floor((k+1)·D/N) > floor(k·D/N).
- R6: When D >= N the channel is high at every position. When D = 0 and N > 0 it is low at every position.
- R7: When the invert bit is set, a transmitting pin shows the complement of the pattern.
- R8: A channel with run clear drives its idle-level bit on the pin, unaffected by invert. This holds from the first cycle after the clock edge that wrote the control word.
- R9: A new range or data value takes effect only at the next period boundary. Setting run starts the period at position 0 with the current values. Until the first step the pin shows the invert bit.
- R10: A channel moves one position only on clock edges where `tick_i` is high, and the pin updates at that edge. Without a step the pin holds.
- R11: With the serializer select bit set, the channel does not transmit and drives its idle level.
- R12: The two channels run independently, each with its own range, data and control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Shared step enable for both channels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_o | output | 2 | Channel pins: bit 0 is channel A, bit 1 is channel B |

## Verification
A wrong position counter or running sum appears at a pin within one period. It shows up as a high step in the wrong slot, or as the wrong count of high steps before the wrap. A latched range or data value taken at the wrong moment shows up in the first period after an update, as a short or mixed period. A fault in the idle or step-gating paths is visible on the very next clock edge: the pin either moves without a step or fails to drop to the idle level.

// File: rtl/duo_pulse_pkg.sv
package duo_pulse_pkg;

    localparam int NUM_CH  = 2;
    localparam int CH_BITS = 8;
    localparam int CTRL_W  = NUM_CH * CH_BITS;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_DMA   = 8'h08;
    localparam logic [7:0] OFS_RNG_A = 8'h10;
    localparam logic [7:0] OFS_DAT_A = 8'h14;
    localparam logic [7:0] OFS_FIFO  = 8'h18;
    localparam logic [7:0] OFS_RNG_B = 8'h20;
    localparam logic [7:0] OFS_DAT_B = 8'h24;

    // fifo-clear action bit of each byte is never stored
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'hBFBF;

    // one control byte, most significant field first
    typedef struct packed {
        logic blk;    // +7 block style
        logic clr;    // +6 fifo clear (action, not stored)
        logic fifo;   // +5 fifo select
        logic inv;    // +4 invert
        logic idle;   // +3 idle level
        logic rpt;    // +2 repeat
        logic ser;    // +1 serializer select
        logic run;    // +0 run
    } chan_cfg_t;

endpackage

// File: rtl/dp_regs.sv
module dp_regs
    import duo_pulse_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [7:0]                     addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    output logic [CTRL_W-1:0]              ctrl,
    output logic [NUM_CH-1:0][CNT_W-1:0]   rng,
    output logic [NUM_CH-1:0][CNT_W-1:0]   dat
);

    typedef struct packed {
        logic [CTRL_W-1:0]            ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0] rng;
        logic [NUM_CH-1:0][CNT_W-1:0] dat;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic is_stored(input logic [7:0] a);
        return (a == OFS_CTRL) || (a == OFS_RNG_A) || (a == OFS_DAT_A) ||
               (a == OFS_RNG_B) || (a == OFS_DAT_B);
    endfunction

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                OFS_CTRL:  r_d.ctrl   = wdata[CTRL_W-1:0] & CTRL_KEEP;
                OFS_RNG_A: r_d.rng[0] = wdata[CNT_W-1:0];
                OFS_DAT_A: r_d.dat[0] = wdata[CNT_W-1:0];
                OFS_RNG_B: r_d.rng[1] = wdata[CNT_W-1:0];
                OFS_DAT_B: r_d.dat[1] = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = 32'(r_q.ctrl);
            OFS_RNG_A: rdata = 32'(r_q.rng[0]);
            OFS_DAT_A: rdata = 32'(r_q.dat[0]);
            OFS_RNG_B: rdata = 32'(r_q.rng[1]);
            OFS_DAT_B: rdata = 32'(r_q.dat[1]);
            default:   rdata = '0;   // status, dma, fifo, unassigned
        endcase
    end

    assign ctrl = r_q.ctrl;
    assign rng  = r_q.rng;
    assign dat  = r_q.dat;

    // R2: a control write stores the written bits minus the action bits
    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CTRL) |=> (r_q.ctrl == ($past(wdata[CTRL_W-1:0]) & CTRL_KEEP)));

    // R3: writes to non-stored offsets leave every register untouched
    p_dead_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !is_stored(addr)) |=> $stable(r_q));

endmodule

// File: rtl/dp_chan.sv
module dp_chan
    import duo_pulse_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  chan_cfg_t         cfg_i,
    input  logic [CNT_W-1:0]  rng_i,
    input  logic [CNT_W-1:0]  dat_i,
    output logic              pin_o
);

    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // position within the period
        logic [CNT_W-1:0] acc;   // running sum for spread style
        logic [CNT_W-1:0] rng;   // latched period length
        logic [CNT_W-1:0] dat;   // latched high count
        logic             hi;    // raw level for the current position
    } chan_st_t;

    chan_st_t s_d, s_q;

    logic             run;
    logic             full;
    logic             wrap;
    logic [SUM_W-1:0] sum;

    assign run = cfg_i.run & ~cfg_i.ser;

    always_comb begin
        s_d  = s_q;
        sum  = {1'b0, s_q.acc} + {1'b0, s_q.dat};
        full = (s_q.dat >= s_q.rng);
        wrap = ({1'b0, s_q.cnt} + SUM_W'(1)) >= {1'b0, s_q.rng};

        if (!run) begin
            // idle: park at position 0 and follow the registers
            s_d.cnt = '0;
            s_d.acc = '0;
            s_d.rng = rng_i;
            s_d.dat = dat_i;
            s_d.hi  = 1'b0;
        end else if (tick_i) begin
            if (full) begin
                s_d.hi = 1'b1;
            end else if (cfg_i.blk) begin
                s_d.hi = (s_q.cnt < s_q.dat);
            end else if (sum >= {1'b0, s_q.rng}) begin
                s_d.hi  = 1'b1;
                s_d.acc = CNT_W'(sum - {1'b0, s_q.rng});
            end else begin
                s_d.hi  = 1'b0;
                s_d.acc = CNT_W'(sum);
            end

            if (wrap) begin
                s_d.cnt = '0;
                s_d.acc = '0;
                s_d.rng = rng_i;
                s_d.dat = dat_i;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_o = run ? (s_q.hi ^ cfg_i.inv) : cfg_i.idle;

    // R9: the position never leaves the latched period
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && s_q.rng != '0) |-> (s_q.cnt < s_q.rng));

    // R10: without a step the raw level holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick_i)) |-> $stable(s_q.hi));

    // R6: data at or above range gives a high step
    p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_i && s_q.dat >= s_q.rng) |=> s_q.hi);

    // R6: zero data gives a low step
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_i && s_q.dat == '0 && s_q.rng != '0) |=> !s_q.hi);

    // R8: an idle channel restarts from a low raw level
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !s_q.hi);

endmodule

// File: rtl/duo_pulse_gen.sv
module duo_pulse_gen
    import duo_pulse_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  pwm_o
);

    logic [CTRL_W-1:0]            ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] rng;
    logic [NUM_CH-1:0][CNT_W-1:0] dat;

    dp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctrl  (ctrl),
        .rng   (rng),
        .dat   (dat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .cfg_i  (chan_cfg_t'(ctrl[c*CH_BITS +: CH_BITS])),
            .rng_i  (rng[c]),
            .dat_i  (dat[c]),
            .pin_o  (pwm_o[c])
        );
    end

endmodule

// File: tb/sim_duo_pulse_gen.sv
module sim_duo_pulse_gen;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model of the requirements
    logic [15:0]  m_ctrl = '0;
    int unsigned  p_rng[2], p_dat[2], a_rng[2], a_dat[2], pos[2];
    bit           m_raw[2];

    always #(CLK_NS/2) clk = ~clk;

    duo_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pwm_o(pwm)
    );

    function automatic bit m_run(int c);
        return m_ctrl[c*8] && !m_ctrl[c*8+1];
    endfunction

    function automatic bit exp_bit(longint unsigned p, longint unsigned n,
                                   longint unsigned d, bit blk);
        if (d >= n) return 1'b1;
        if (blk)    return p < d;
        return ((p + 1) * d) / n != (p * d) / n;
    endfunction

    function automatic bit exp_pin(int c);
        if (m_run(c)) return m_raw[c] ^ m_ctrl[c*8+4];
        return m_ctrl[c*8+3];
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_pins(input string req);
        chk(32'(pwm[0]), 32'(exp_pin(0)), req);
        chk(32'(pwm[1]), 32'(exp_pin(1)), req);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(rdata, exp, req);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] v);
        bit was[2];
        for (int c = 0; c < 2; c++) was[c] = m_run(c);
        tick = 1'b0; we = 1'b1; addr = a; wdata = v;
        @(posedge clk); #1;
        we = 1'b0;
        case (a)
            8'h00: m_ctrl   = v[15:0] & 16'hBFBF;
            8'h10: p_rng[0] = v;
            8'h14: p_dat[0] = v;
            8'h20: p_rng[1] = v;
            8'h24: p_dat[1] = v;
            default: ;
        endcase
        for (int c = 0; c < 2; c++) begin
            if (!m_run(c) || !was[c]) begin
                m_raw[c] = 1'b0; pos[c] = 0;
                a_rng[c] = p_rng[c]; a_dat[c] = p_dat[c];
            end
        end
    endtask

    task automatic step(input bit t, input string req);
        tick = t;
        @(posedge clk); #1;
        if (t) begin
            for (int c = 0; c < 2; c++) begin
                if (m_run(c)) begin
                    m_raw[c] = exp_bit(pos[c], a_rng[c], a_dat[c], m_ctrl[c*8+7]);
                    pos[c]++;
                    if (pos[c] >= a_rng[c]) begin
                        pos[c] = 0; a_rng[c] = p_rng[c]; a_dat[c] = p_dat[c];
                    end
                end
            end
        end
        chk_pins(req);
    endtask

    task automatic run_div(input int n, input int div, input string req);
        for (int i = 0; i < n; i++) step((i % div) == div - 1, req);
    endtask

    task automatic setup_a(input int unsigned n, input int unsigned d, input logic [7:0] cb);
        reg_wr(8'h00, 32'h0);
        reg_wr(8'h10, n);
        reg_wr(8'h14, d);
        reg_wr(8'h00, {24'h0, cb});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd1357);
        for (int c = 0; c < 2; c++) begin
            p_rng[c] = 0; p_dat[c] = 0; a_rng[c] = 0; a_dat[c] = 0; pos[c] = 0; m_raw[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 ctrl");
        rd_chk(8'h10, 32'h0, "R1 range A");
        rd_chk(8'h24, 32'h0, "R1 data B");
        chk(32'(pwm), 32'h0, "R1 pins");

        // R2 control mask, R11 serializer select forces idle level
        reg_wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_BFBF, "R2 ctrl readback");
        chk_pins("R11 serializer idle");
        run_div(4, 1, "R11 serializer idle with steps");
        reg_wr(8'h00, 32'h0);
        reg_wr(8'h20, 32'h1234_5678);
        rd_chk(8'h20, 32'h1234_5678, "R2 range B readback");

        // R3 dead offsets
        reg_wr(8'h04, 32'hFFFF_FFFF);
        reg_wr(8'h08, 32'hFFFF_FFFF);
        reg_wr(8'h18, 32'hFFFF_FFFF);
        reg_wr(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0, "R3 status");
        rd_chk(8'h08, 32'h0, "R3 dma");
        rd_chk(8'h18, 32'h0, "R3 fifo");
        rd_chk(8'h30, 32'h0, "R3 unassigned");
        rd_chk(8'h00, 32'h0, "R3 ctrl untouched");
        rd_chk(8'h20, 32'h1234_5678, "R3 range B untouched");
        reg_wr(8'h20, 32'h0);

        // R4 block style, R5 spread style
        setup_a(10, 3, 8'h81);
        run_div(25, 1, "R4 block 3/10");
        setup_a(10, 3, 8'h01);
        run_div(25, 1, "R5 spread 3/10");
        setup_a(7, 5, 8'h01);
        run_div(21, 1, "R5 spread 5/7");

        // R6 saturation and zero
        setup_a(10, 12, 8'h81);
        run_div(12, 1, "R6 block full");
        setup_a(10, 10, 8'h01);
        run_div(12, 1, "R6 spread full");
        setup_a(6, 0, 8'h01);
        run_div(12, 1, "R6 spread zero");

        // R7 invert
        setup_a(6, 2, 8'h91);
        run_div(14, 1, "R7 invert block");

        // R8 disable goes to idle level at once, invert not applied
        reg_wr(8'h00, 32'h0000_0008);
        chk(32'(pwm[0]), 32'h1, "R8 idle high after disable");
        reg_wr(8'h00, 32'h0000_0010);
        chk(32'(pwm[0]), 32'h0, "R8 idle low ignores invert");

        // R9 update held until boundary, first step from position 0
        setup_a(8, 2, 8'h91);
        chk(32'(pwm[0]), 32'h1, "R9 pin before first step");
        run_div(3, 1, "R9 first period");
        reg_wr(8'h14, 6);
        reg_wr(8'h10, 5);
        run_div(20, 1, "R9 deferred update");

        // R10 step gating
        setup_a(5, 2, 8'h01);
        run_div(45, 3, "R10 step every third");

        // R12 channel B alone, then both
        reg_wr(8'h00, 32'h0);
        reg_wr(8'h20, 9);
        reg_wr(8'h24, 4);
        reg_wr(8'h00, 32'h0000_8108);
        run_div(20, 1, "R12 channel B alone");

        for (int it = 0; it < 10; it++) begin
            logic [7:0] cb[2];
            reg_wr(8'h00, 32'h0);
            for (int c = 0; c < 2; c++) begin
                reg_wr(8'(8'h10 + c*16), 1 + ($urandom % 20));
                reg_wr(8'(8'h14 + c*16), $urandom % 25);
                cb[c] = 8'h01 | {($urandom % 2) == 1, 3'b000, ($urandom % 2) == 1,
                                 ($urandom % 2) == 1, 2'b00};
            end
            reg_wr(8'h00, {16'h0, cb[1], cb[0]});
            for (int i = 0; i < 60; i++) begin
                if (i == 25) reg_wr(8'h24, $urandom % 25);
                step(($urandom % 3) != 0, "R12 random pair");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule